// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block puts bytes on a serial line and takes them off again. Its transmit half takes an 8-bit word over a valid/ready handshake. It sends the word as a character frame: a low start bit, the data least significant bit first, an optional parity bit, and one or two high stop bits. Its receive half oversamples the incoming line sixteen times per bit period and rebuilds each character. It hands the byte over with a one-cycle strobe, along with parity and framing error flags for that character.

The frame shape is chosen at run time. Parity can be switched on or off, and when it is on it can be even or odd. One or two stop bits can be chosen. A clocked synchronous mode sends and takes exactly eight data bits per character, with no framing bits, using a bit clock that the block drives out and takes back in. In that mode the parity and stop settings play no part. The bit period is a fixed number of system clocks, set at build time by a divider.

Top module: `sercom_framer`

## Requirements
- R1: The idle transmit line is 1. An asynchronous frame starts with a 0 start bit, then sends the 8 data bits least significant first. Each bit lasts 16*CLK_DIV system clocks.
- R2: With parity on, one parity bit follows the data. With even parity (cfg_par_odd=0), data plus parity holds an even count of ones. With odd parity, it holds an odd count. With parity off, no parity bit is sent.
- R3: One stop bit (cfg_two_stop=0) or two stop bits (cfg_two_stop=1), each at 1, end every asynchronous frame.
- R4: A byte is taken when tx_valid and tx_ready are both high at a clock edge. tx_ready then stays low until the last bit of the frame has been driven for a full bit period, which is the frame length in bits times 16*CLK_DIV cycles.
- R5: The receiver presents each rebuilt byte on rx_data with rx_valid high for exactly one cycle. rx_par_err and rx_frm_err belong to that same character.
- R6: rx_par_err is set when parity is on and the received data plus parity bit lacks the count of ones that the selected mode requires. It is 0 when parity is off.
- R7: The receiver samples only the first stop bit. If that bit is 0, rx_frm_err is set.
- R8: The second stop slot is never checked. A 0 in that slot is taken as the start bit of the next character, and neither character reports a framing error.
- R9: A start bit is sampled again at mid-bit. If the line is back at 1 by then, the event is dropped and no character is produced.
- R10: In synchronous mode (cfg_sync=1), a frame is the 8 data bits alone. During each bit, sclk_out is low for the first half and high for the second half. The receiver shifts in rxd on each rising edge of sclk_in and strobes every 8 bits with both flags at 0. The parity and stop settings have no effect.
- R11: After reset, tx_ready=1, txd=1, sclk_out=1 and rx_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sync | input | 1 | 1 selects clocked synchronous mode |
| cfg_par_en | input | 1 | Parity bit on |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial transmit line |
| sclk_out | output | 1 | Bit clock driven in synchronous mode, idles high |
| rxd | input | 1 | Serial receive line |
| sclk_in | input | 1 | Bit clock received in synchronous mode |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_par_err | output | 1 | Parity error for the strobed byte |
| rx_frm_err | output | 1 | Framing error for the strobed byte |

## Verification
Two receiver events can fall in the same stretch of cycles: the strobe that ends one character after its first stop bit, and the start detection for the next character. The bench provokes this by driving a frame whose second stop slot is already low, so the next start bit follows straight after. It then expects two correct bytes with no framing error. A bad stop bit followed by a short low tail sets the framing check against start detection. The judgement there is that exactly one flagged byte arrives and the line recovers for the next frame.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
    localparam int BYTE_W = 8;
    localparam int OVS    = 16;
    localparam int TCW    = $clog2(OVS);
    localparam int BIW    = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_st_e;
endpackage

// File: rtl/sercom_tick.sv
module sercom_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sercom_sync.sv
module sercom_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_sync,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              sclk_out
);
    typedef struct packed {
        tx_st_e            st;
        logic [TCW-1:0]    tcnt;
        logic [BIW-1:0]    bidx;
        logic [BYTE_W-1:0] shreg;
        logic              par;
        logic              sync;
        logic              par_en;
        logic              two_stop;
    } tx_reg_t;

    tx_reg_t q, d;
    logic    bit_end;

    always_comb begin
        d       = q;
        bit_end = tick && (q.tcnt == TCW'(OVS - 1));
        if (q.st == TX_IDLE) begin
            if (tx_valid) begin
                d.shreg    = tx_data;
                d.par      = (^tx_data) ^ cfg_par_odd;
                d.sync     = cfg_sync;
                d.par_en   = cfg_par_en;
                d.two_stop = cfg_two_stop;
                d.tcnt     = '0;
                d.bidx     = '0;
                d.st       = cfg_sync ? TX_DATA : TX_START;
            end
        end else if (tick) begin
            d.tcnt = bit_end ? '0 : q.tcnt + 1'b1;
        end

        if (bit_end) begin
            unique case (q.st)
                TX_START: d.st = TX_DATA;
                TX_DATA: begin
                    d.shreg = {1'b0, q.shreg[BYTE_W-1:1]};
                    if (q.bidx == BIW'(BYTE_W - 1)) begin
                        if (q.sync)        d.st = TX_IDLE;
                        else if (q.par_en) d.st = TX_PAR;
                        else               d.st = TX_STOP1;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
                TX_PAR:   d.st = TX_STOP1;
                TX_STOP1: d.st = q.two_stop ? TX_STOP2 : TX_IDLE;
                TX_STOP2: d.st = TX_IDLE;
                default:  d.st = TX_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_ready = (q.st == TX_IDLE);
        unique case (q.st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = q.shreg[0];
            TX_PAR:   txd = q.par;
            default:  txd = 1'b1;
        endcase
        sclk_out = !((q.st == TX_DATA) && q.sync && (q.tcnt < TCW'(OVS / 2)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= TX_IDLE;
            q.tcnt     <= '0;
            q.bidx     <= '0;
            q.shreg    <= '0;
            q.par      <= 1'b0;
            q.sync     <= 1'b0;
            q.par_en   <= 1'b0;
            q.two_stop <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_sync,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rx_s,
    input  logic              sclk_s,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err
);
    typedef struct packed {
        rx_st_e            st;
        logic [TCW-1:0]    tcnt;
        logic [BIW-1:0]    bidx;
        logic [BYTE_W-1:0] shreg;
        logic              perr;
        logic              sclk_prev;
        logic [BYTE_W-1:0] out_data;
        logic              out_valid;
        logic              out_perr;
        logic              out_ferr;
    } rx_reg_t;

    rx_reg_t q, d;
    logic    mid_start, mid_bit;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.sclk_prev = sclk_s;
        mid_start   = tick && (q.tcnt == TCW'(OVS / 2 - 1));
        mid_bit     = tick && (q.tcnt == TCW'(OVS - 1));
        shifted     = {rx_s, q.shreg[BYTE_W-1:1]};

        if (cfg_sync) begin
            d.st   = RX_IDLE;
            d.tcnt = '0;
            if (sclk_s && !q.sclk_prev) begin
                d.shreg = shifted;
                if (q.bidx == BIW'(BYTE_W - 1)) begin
                    d.bidx      = '0;
                    d.out_valid = 1'b1;
                    d.out_data  = shifted;
                    d.out_perr  = 1'b0;
                    d.out_ferr  = 1'b0;
                end else begin
                    d.bidx = q.bidx + 1'b1;
                end
            end
        end else begin
            if (tick && (q.st != RX_IDLE)) d.tcnt = q.tcnt + 1'b1;
            unique case (q.st)
                RX_IDLE: begin
                    d.bidx = '0;
                    d.tcnt = '0;
                    if (tick && !rx_s) d.st = RX_START;
                end
                RX_START: begin
                    if (mid_start) begin
                        d.tcnt = '0;
                        d.perr = 1'b0;
                        d.bidx = '0;
                        d.st   = rx_s ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (mid_bit) begin
                        d.shreg = shifted;
                        if (q.bidx == BIW'(BYTE_W - 1))
                            d.st = cfg_par_en ? RX_PAR : RX_STOP;
                        else
                            d.bidx = q.bidx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (mid_bit) begin
                        d.perr = ((^q.shreg) ^ rx_s) != cfg_par_odd;
                        d.st   = RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (mid_bit) begin
                        d.out_valid = 1'b1;
                        d.out_data  = q.shreg;
                        d.out_perr  = cfg_par_en && q.perr;
                        d.out_ferr  = !rx_s;
                        d.st        = RX_IDLE;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    assign rx_data    = q.out_data;
    assign rx_valid   = q.out_valid;
    assign rx_par_err = q.out_perr;
    assign rx_frm_err = q.out_ferr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= RX_IDLE;
            q.tcnt      <= '0;
            q.bidx      <= '0;
            q.shreg     <= '0;
            q.perr      <= 1'b0;
            q.sclk_prev <= 1'b1;
            q.out_data  <= '0;
            q.out_valid <= 1'b0;
            q.out_perr  <= 1'b0;
            q.out_ferr  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sercom_framer.sv
module sercom_framer
    import sercom_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sync,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              sclk_out,
    input  logic              rxd,
    input  logic              sclk_in,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_par_err,
    output logic              rx_frm_err
);
    logic       tick;
    logic [1:0] line_s;

    sercom_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sercom_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sclk_in, rxd}),
        .dout  (line_s)
    );

    sercom_tx u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cfg_sync     (cfg_sync),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .txd          (txd),
        .sclk_out     (sclk_out)
    );

    sercom_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cfg_sync    (cfg_sync),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rx_s        (line_s[0]),
        .sclk_s      (line_s[1]),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_par_err  (rx_par_err),
        .rx_frm_err  (rx_frm_err)
    );
endmodule

// File: rtl/sercom_framer_chk.sv
module sercom_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sync,
    input logic cfg_par_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic sclk_out,
    input logic rx_valid,
    input logic rx_par_err,
    input logic rx_frm_err
);
    // R4: an accepted byte makes the transmitter busy on the next cycle
    a_r4_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R1: while ready, the line and the bit clock rest high
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (txd && sclk_out));

    // R5: the receive strobe never lasts two cycles
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: synchronous characters carry no error flags
    a_r10_sync_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sync && rx_valid) |-> !(rx_par_err || rx_frm_err));

    // R6: with parity off no parity error is reported
    a_r6_par_off_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sync && !cfg_par_en && rx_valid) |-> !rx_par_err);
endmodule

bind sercom_framer sercom_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sync   (cfg_sync),
    .cfg_par_en (cfg_par_en),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .txd        (txd),
    .sclk_out   (sclk_out),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err)
);

// File: tb/sercom_framer_bench.sv
module sercom_framer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 1;
    localparam int BIT_CYC    = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sync = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, sclk_out;
    logic       loop_sel = 1'b1;
    logic       drv_rxd = 1'b1;
    logic       rxd;
    logic [7:0] rx_data;
    logic       rx_valid, rx_par_err, rx_frm_err;

    int n_chk = 0;
    int n_bad = 0;
    int rx_cnt = 0;
    bit done = 1'b0;
    logic [7:0] cap_d [8];
    logic       cap_p [8];
    logic       cap_f [8];

    assign rxd = loop_sel ? txd : drv_rxd;

    sercom_framer #(.CLK_DIV(DIV)) u_sercom_framer (
        .clk(clk), .rst_n(rst_n),
        .cfg_sync(cfg_sync), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .txd(txd), .sclk_out(sclk_out),
        .rxd(rxd), .sclk_in(sclk_out),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            cap_d[rx_cnt[2:0]] = rx_data;
            cap_p[rx_cnt[2:0]] = rx_par_err;
            cap_f[rx_cnt[2:0]] = rx_frm_err;
            rx_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Loopback: send one byte, check the line bit by bit, busy time and received copy
    task automatic send_byte(input logic [7:0] b);
        logic [15:0] fr;
        int nb, pidx, lowcnt, mm_data, mm_par, mm_stop, mm_clk, base;
        fr = '1;
        lowcnt = 0; mm_data = 0; mm_par = 0; mm_stop = 0; mm_clk = 0; pidx = -1;
        if (cfg_sync) begin
            fr[7:0] = b;
            nb = 8;
        end else begin
            fr[0] = 1'b0;
            fr[8:1] = b;
            nb = 9;
            if (cfg_par_en) begin
                fr[nb] = (^b) ^ cfg_par_odd;
                pidx = nb;
                nb++;
            end
            nb += cfg_two_stop ? 2 : 1;
        end
        base = rx_cnt;
        @(negedge clk);
        tx_data = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int n = 1; n <= nb * BIT_CYC + 1; n++) begin
            if (n > 1) @(negedge clk);
            if (!tx_ready) lowcnt++;
            if ((n % BIT_CYC) == BIT_CYC / 2 && n <= nb * BIT_CYC) begin
                int bi;
                bi = (n - 1) / BIT_CYC;
                if (txd != fr[bi]) begin
                    if (bi == pidx) mm_par++;
                    else if (!cfg_sync && bi > 8) mm_stop++;
                    else mm_data++;
                end
            end
            if (cfg_sync && n <= nb * BIT_CYC) begin
                if ((n - 1) % BIT_CYC == BIT_CYC / 4 && sclk_out != 1'b0) mm_clk++;
                if ((n - 1) % BIT_CYC == 3 * BIT_CYC / 4 && sclk_out != 1'b1) mm_clk++;
            end
        end
        if (cfg_sync) begin
            chk("R10 sync data bits", mm_data, 0);
            chk("R10 sync bit clock", mm_clk, 0);
            chk("R10 busy cycles", lowcnt, nb * BIT_CYC);
        end else begin
            chk("R1 start and data bits", mm_data, 0);
            if (cfg_par_en) chk("R2 parity bit", mm_par, 0);
            chk("R3 stop bits", mm_stop, 0);
            chk("R4 busy cycles", lowcnt, nb * BIT_CYC);
        end
        repeat (4) @(negedge clk);
        chk("R5 one strobe per byte", rx_cnt - base, 1);
        chk("R5 received byte", cap_d[base[2:0]], b);
        chk("R6 parity flag clear", cap_p[base[2:0]], 0);
        chk("R7 framing flag clear", cap_f[base[2:0]], 0);
    endtask

    task automatic drive_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            drv_rxd = bits[i];
            repeat (BIT_CYC) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] b;
        repeat (2) @(negedge clk);
        // R11: reset state
        chk("R11 tx_ready", tx_ready, 1);
        chk("R11 txd", txd, 1);
        chk("R11 sclk_out", sclk_out, 1);
        chk("R11 rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Asynchronous sweep over all eight settings; full byte range for one
        for (int c = 0; c < 8; c++) begin
            cfg_par_en = c[0];
            cfg_par_odd = c[1];
            cfg_two_stop = c[2];
            for (int k = 0; k < ((c == 7) ? 256 : 24); k++) begin
                b = (c == 7) ? 8'(k) : 8'(k * 37 + c * 11);
                send_byte(b);
            end
        end

        // Direct drive of the receive line
        loop_sel = 1'b0;
        drv_rxd = 1'b1;
        repeat (8) @(negedge clk);

        // R6: wrong parity bit, even mode
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
        base = rx_cnt;
        drive_bits({5'b11111, 1'b1, ~(^8'hA5), 8'hA5, 1'b0}, 12);
        repeat (2 * BIT_CYC) @(negedge clk);
        chk("R6 strobe on bad parity", rx_cnt - base, 1);
        chk("R6 parity error set", cap_p[base[2:0]], 1);
        chk("R6 data kept", cap_d[base[2:0]], 8'hA5);
        // R6: wrong parity bit, odd mode
        cfg_par_odd = 1'b1;
        base = rx_cnt;
        drive_bits({5'b11111, 1'b1, (^8'h3C), 8'h3C, 1'b0}, 12);
        repeat (2 * BIT_CYC) @(negedge clk);
        chk("R6 odd parity error set", cap_p[base[2:0]], 1);

        // R7: first stop bit low
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        base = rx_cnt;
        drive_bits({6'b111111, 1'b0, 8'h5A, 1'b0}, 10);
        drv_rxd = 1'b1;
        repeat (4 * BIT_CYC) @(negedge clk);
        chk("R7 framing error set", cap_f[base[2:0]], 1);
        chk("R7 data kept", cap_d[base[2:0]], 8'h5A);
        chk("R7 single character", rx_cnt - base, 1);

        // R8: second stop slot low starts the next character
        cfg_two_stop = 1'b1;
        base = rx_cnt;
        drive_bits({6'b111111, 1'b1, 8'hC3, 1'b0}, 10);
        drive_bits({6'b111111, 1'b1, 8'h18, 1'b0}, 10);
        drv_rxd = 1'b1;
        repeat (3 * BIT_CYC) @(negedge clk);
        chk("R8 two characters", rx_cnt - base, 2);
        chk("R8 first byte", cap_d[base[2:0]], 8'hC3);
        chk("R8 second byte", cap_d[3'(base + 1)], 8'h18);
        chk("R8 no framing error first", cap_f[base[2:0]], 0);
        chk("R8 no framing error second", cap_f[3'(base + 1)], 0);

        // R9: short low pulse is not a start bit
        base = rx_cnt;
        drv_rxd = 1'b0;
        repeat (3) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (4 * BIT_CYC) @(negedge clk);
        chk("R9 glitch ignored", rx_cnt - base, 0);
        drive_bits({6'b111111, 1'b1, 8'h81, 1'b0}, 10);
        repeat (2 * BIT_CYC) @(negedge clk);
        chk("R9 recovery count", rx_cnt - base, 1);
        chk("R9 recovery byte", cap_d[base[2:0]], 8'h81);

        // R10: synchronous mode with the async settings all set, which must not matter
        loop_sel = 1'b1;
        cfg_sync = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
        do_reset();
        for (int k = 0; k < 64; k++) begin
            b = 8'(k * 53 + 7);
            send_byte(b);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule